// File: doc/BRIEF.md
# Dual-Path Serial Clock Rate Generator

This block paces the shift engine of a serial peripheral interface master. It runs on the source clock and emits a one-cycle strobe, `tick_o`, twice per serial clock period: once for each serial clock edge. The shift engine toggles its clock on each strobe. The spacing of the strobes comes from one of two division laws, picked by a select input:

- **Power-of-two law.** A fixed divide-by-4, followed by 2^E, where E is a 3-bit exponent.
- **Linear law.** A fixed divide-by-2, followed by N+1, where N is an 8-bit divisor.

The divider runs only while the controller is enabled and a burst is in progress. A new divisor or a new path selection is taken in at only two points: while no burst runs, or at the end of a strobe period. A period in progress is therefore never cut short or stretched.

An optional lead delay holds off the first strobe of a burst for a programmed number of source cycles. This gives the chip select a setup time before the first clock edge.

Top module: `sclk_rate_gen`

## Requirements
- R1: With `lin_sel_i`=0, strobes repeat every 2^(E+1) source cycles, where E is `pow2_exp_i`. The serial clock division is then 4·2^E, so codes 0, 1, 2 and 3 give divisions of 4, 8, 16 and 32.
- R2: With `lin_sel_i`=1, strobes repeat every N+1 source cycles, where N is `lin_div_i`, for a serial clock division of 2·(N+1). N=0 gives a strobe on every cycle, which is a division of exactly 2.
- R3: Let cycle 0 be the first cycle in which `burst_i` and `enable_i` are both high, and let P be the strobe period. With no lead delay, the first strobe appears in cycle P−1.
- R4: While `enable_i` is low, `tick_o` stays low. The divider restarts from a full period once `enable_i` returns high during a burst, and that restart counts as a new burst start.
- R5: While `burst_i` is low, `tick_o` stays low.
- R6: A configuration change made during a burst leaves the current period at its old length. The new period applies from the strobe that ends the current period. The configuration sampled in a strobe cycle sets the length of the next period.
- R7: Configuration changes made between bursts take effect from the first period of the next burst.
- R8: With `lead_en_i`=1 and `lead_dly_i`=L>0, no strobe appears in cycles 0 to L−1 of a burst, and the first strobe appears in cycle L+P−1. With `lead_en_i`=0, `lead_dly_i` has no effect.
- R9: With `lead_en_i`=1 and `lead_dly_i`=0, the first strobe comes in cycle P−1, as if no delay were set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Controller enable; when low, the counters are cleared |
| burst_i | input | 1 | High while the shift engine runs a burst |
| lin_sel_i | input | 1 | 1 selects the linear law, 0 selects the power-of-two law |
| pow2_exp_i | input | 3 | Exponent E of the power-of-two law |
| lin_div_i | input | 8 | Divisor N of the linear law |
| lead_en_i | input | 1 | Enables the lead delay at burst start |
| lead_dly_i | input | 16 | Lead delay in source cycles |
| tick_o | output | 1 | Serial clock edge strobe |

## Verification
The checker watches four behaviours on every cycle:

- strobes stay silent while the block is disabled or idle;
- back-to-back strobes appear only when the configuration sampled at the earlier strobe is the linear law with N=0;
- a burst that starts with that setting strobes at once;
- a burst that starts with a nonzero lead delay does not strobe in its first cycle.

The exact spacing laws cannot be shown cycle by cycle. Nor can the placement of the first strobe after a lead delay, or the rule that a mid-burst change waits for the end of the current period. The bench shows these by sweeping every exponent and a spread of linear divisors and measuring strobe positions against arithmetic expectations.

// File: rtl/rcg_pkg.sv
package rcg_pkg;

  // Default field widths shared by the generator and its bench.
  localparam int unsigned DEF_EXP_W = 3;
  localparam int unsigned DEF_LIN_W = 8;
  localparam int unsigned DEF_DLY_W = 16;

  // Encoding of the path select input.
  typedef enum logic {
    PATH_POW2 = 1'b0,
    PATH_LIN  = 1'b1
  } path_e;

endpackage

// File: rtl/rcg_cfg_hold.sv
// Holds the committed divider configuration. It passes a new one through only when load is high.
module rcg_cfg_hold #(
  parameter int unsigned EXP_W = 3,
  parameter int unsigned LIN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             sel_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LIN_W-1:0] lin_i,
  output logic             sel_o,
  output logic [EXP_W-1:0] exp_o,
  output logic [LIN_W-1:0] lin_o
);
  import rcg_pkg::*;

  path_e            sel_q;
  logic [EXP_W-1:0] exp_q;
  logic [LIN_W-1:0] lin_q;
  path_e            sel_d;
  logic [EXP_W-1:0] exp_d;
  logic [LIN_W-1:0] lin_d;

  always_comb begin
    if (load_i) begin
      sel_d = path_e'(sel_i);
      exp_d = exp_i;
      lin_d = lin_i;
    end else begin
      sel_d = sel_q;
      exp_d = exp_q;
      lin_d = lin_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= PATH_POW2;
      exp_q <= '0;
      lin_q <= '0;
    end else if (load_i) begin
      sel_q <= sel_d;
      exp_q <= exp_d;
      lin_q <= lin_d;
    end
  end

  // Configuration in force for the coming period.
  assign sel_o = (sel_d == PATH_LIN);
  assign exp_o = exp_d;
  assign lin_o = lin_d;

endmodule

// File: rtl/rcg_period.sv
// Converts a configuration into a reload value, which is the strobe period minus one.
module rcg_period #(
  parameter int unsigned EXP_W = 3,
  parameter int unsigned LIN_W = 8,
  parameter int unsigned CNT_W = 8
) (
  input  logic             sel_i,
  input  logic [EXP_W-1:0] exp_i,
  input  logic [LIN_W-1:0] lin_i,
  output logic [CNT_W-1:0] reload_o
);
  localparam int unsigned NEXP = 1 << EXP_W;

  logic [CNT_W-1:0] pow2_tab [NEXP];

  // Power-of-two law: the period is 2^(e+1) source cycles.
  for (genvar g = 0; g < NEXP; g++) begin : g_pow2
    localparam logic [CNT_W:0] PER = (CNT_W+1)'(1) << (g + 1);
    assign pow2_tab[g] = CNT_W'(PER - 1'b1);
  end

  always_comb begin
    if (sel_i) reload_o = CNT_W'(lin_i);
    else       reload_o = pow2_tab[exp_i];
  end

endmodule

// File: rtl/rcg_lead_gate.sv
// Detects a burst start and holds off the divider for the lead delay.
module rcg_lead_gate #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             burst_i,
  input  logic             lead_en_i,
  input  logic [DLY_W-1:0] lead_dly_i,
  output logic             start_o,
  output logic             busy_o
);
  logic             live;
  logic             live_q;
  logic [DLY_W-1:0] cnt_q;
  logic [DLY_W-1:0] cnt_d;
  logic             arm;

  assign live    = enable_i & burst_i;
  assign start_o = live & ~live_q;
  assign arm     = start_o & lead_en_i & (lead_dly_i != '0);
  assign busy_o  = arm | (cnt_q != '0);

  always_comb begin
    if (!live)               cnt_d = '0;
    else if (arm)            cnt_d = lead_dly_i - 1'b1;
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    else                     cnt_d = cnt_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      live_q <= live;
      cnt_q  <= cnt_d;
    end
  end

endmodule

// File: rtl/rcg_div_count.sv
// Down counter that produces the strobe and reloads from the incoming configuration.
module rcg_div_count #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             run_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             term_o,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] eff;
  logic             zero;

  // On the first cycle of a burst, count from a fresh reload.
  assign eff    = start_i ? reload_i : cnt_q;
  assign zero   = (eff == '0);
  assign tick_o = run_i & zero;
  // The end of a period in progress, which does not depend on reload.
  assign term_o = run_i & ~start_i & (cnt_q == '0);

  always_comb begin
    if (!enable_i)  cnt_d = '0;
    else if (!run_i) cnt_d = reload_i;
    else if (zero)  cnt_d = reload_i;
    else            cnt_d = eff - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sclk_rate_gen.sv
// Dual-law serial clock strobe generator.
module sclk_rate_gen #(
  parameter int unsigned EXP_W = rcg_pkg::DEF_EXP_W,
  parameter int unsigned LIN_W = rcg_pkg::DEF_LIN_W,
  parameter int unsigned DLY_W = rcg_pkg::DEF_DLY_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enable_i,
  input  logic             burst_i,
  input  logic             lin_sel_i,
  input  logic [EXP_W-1:0] pow2_exp_i,
  input  logic [LIN_W-1:0] lin_div_i,
  input  logic             lead_en_i,
  input  logic [DLY_W-1:0] lead_dly_i,
  output logic             tick_o
);
  localparam int unsigned POW_W = 1 << EXP_W;
  localparam int unsigned CNT_W = (POW_W > LIN_W) ? POW_W : LIN_W;

  logic             start;
  logic             busy;
  logic             run;
  logic             term;
  logic             load;
  logic             sel_n;
  logic [EXP_W-1:0] exp_n;
  logic [LIN_W-1:0] lin_n;
  logic [CNT_W-1:0] reload;

  assign run  = enable_i & burst_i & ~busy;
  // Commit when idle, at burst start, or at the end of a period.
  assign load = ~(enable_i & burst_i) | start | term;

  rcg_lead_gate #(.DLY_W(DLY_W)) u_lead (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .enable_i  (enable_i),
    .burst_i   (burst_i),
    .lead_en_i (lead_en_i),
    .lead_dly_i(lead_dly_i),
    .start_o   (start),
    .busy_o    (busy)
  );

  rcg_cfg_hold #(.EXP_W(EXP_W), .LIN_W(LIN_W)) u_cfg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .sel_i (lin_sel_i),
    .exp_i (pow2_exp_i),
    .lin_i (lin_div_i),
    .sel_o (sel_n),
    .exp_o (exp_n),
    .lin_o (lin_n)
  );

  rcg_period #(.EXP_W(EXP_W), .LIN_W(LIN_W), .CNT_W(CNT_W)) u_per (
    .sel_i   (sel_n),
    .exp_i   (exp_n),
    .lin_i   (lin_n),
    .reload_o(reload)
  );

  rcg_div_count #(.CNT_W(CNT_W)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .enable_i(enable_i),
    .run_i   (run),
    .start_i (start & ~busy),
    .reload_i(reload),
    .term_o  (term),
    .tick_o  (tick_o)
  );

endmodule

// File: rtl/sclk_rate_gen_chk.sv
module sclk_rate_gen_chk #(
  parameter int unsigned EXP_W = 3,
  parameter int unsigned LIN_W = 8,
  parameter int unsigned DLY_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             enable_i,
  input logic             burst_i,
  input logic             lin_sel_i,
  input logic [EXP_W-1:0] pow2_exp_i,
  input logic [LIN_W-1:0] lin_div_i,
  input logic             lead_en_i,
  input logic [DLY_W-1:0] lead_dly_i,
  input logic             tick_o
);

  p_quiet_disabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |-> !tick_o);

  p_quiet_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !burst_i |-> !tick_o);

  // Back-to-back strobes require the unit linear period sampled at the earlier strobe (R2, R6).
  p_unit_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && $past(tick_o)) |-> ($past(lin_sel_i) && $past(lin_div_i) == '0));

  p_first_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && burst_i && !($past(burst_i) && $past(enable_i)) && !lead_en_i
     && lin_sel_i && lin_div_i == '0) |-> tick_o);

  p_lead_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (enable_i && burst_i && !($past(burst_i) && $past(enable_i)) && lead_en_i
     && lead_dly_i != '0) |-> !tick_o);

endmodule

bind sclk_rate_gen sclk_rate_gen_chk #(.EXP_W(EXP_W), .LIN_W(LIN_W), .DLY_W(DLY_W)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .enable_i  (enable_i),
  .burst_i   (burst_i),
  .lin_sel_i (lin_sel_i),
  .pow2_exp_i(pow2_exp_i),
  .lin_div_i (lin_div_i),
  .lead_en_i (lead_en_i),
  .lead_dly_i(lead_dly_i),
  .tick_o    (tick_o)
);

// File: tb/sclk_rate_gen_tb_top.sv
module sclk_rate_gen_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        en;
  logic        burst;
  logic        sel;
  logic [2:0]  ex;
  logic [7:0]  lin;
  logic        lead_en;
  logic [15:0] lead_dly;
  logic        tick;

  int n_chk  = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sclk_rate_gen dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .enable_i  (en),
    .burst_i   (burst),
    .lin_sel_i (sel),
    .pow2_exp_i(ex),
    .lin_div_i (lin),
    .lead_en_i (lead_en),
    .lead_dly_i(lead_dly),
    .tick_o    (tick)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int period(input logic s, input int e, input int n);
    if (s) return n + 1;
    return 1 << (e + 1);
  endfunction

  // Runs one burst and checks the first strobe position and three further gaps.
  task automatic go_burst(input logic s, input int e, input int n, input logic le,
                          input int d, input string req);
    int p;
    int lead;
    int w;
    int k;
    int hits[4];
    p    = period(s, e, n);
    lead = (le && d > 0) ? d : 0;
    w    = lead + 4 * p;
    @(negedge clk);
    burst = 1'b0; sel = s; ex = 3'(e); lin = 8'(n); lead_en = le; lead_dly = 16'(d);
    repeat (2) @(negedge clk);
    burst = 1'b1;
    k = 0;
    for (int c = 0; c < w; c++) begin
      #1;
      if (tick) begin
        if (k < 4) hits[k] = c;
        k++;
      end
      @(negedge clk);
    end
    burst = 1'b0;
    check(k == 4, req, k, 4);
    if (k >= 4) begin
      check(hits[0] == lead + p - 1, req, hits[0], lead + p - 1);
      for (int i = 1; i < 4; i++)
        check(hits[i] - hits[i-1] == p, req, hits[i] - hits[i-1], p);
    end
  endtask

  // Records strobe cycles over a window, switching the configuration at cycle sw.
  task automatic mid_change(input logic s0, input int e0, input int n0,
                            input logic s1, input int e1, input int n1,
                            input int sw, input int w, input int expc[4], input string req);
    int k;
    int hits[4];
    @(negedge clk);
    burst = 1'b0; sel = s0; ex = 3'(e0); lin = 8'(n0); lead_en = 1'b0; lead_dly = '0;
    repeat (2) @(negedge clk);
    burst = 1'b1;
    k = 0;
    for (int c = 0; c < w; c++) begin
      if (c == sw) begin sel = s1; ex = 3'(e1); lin = 8'(n1); end
      #1;
      if (tick) begin
        if (k < 4) hits[k] = c;
        k++;
      end
      @(negedge clk);
    end
    burst = 1'b0;
    check(k >= 4, req, k, 4);
    if (k >= 4)
      for (int i = 0; i < 4; i++) check(hits[i] == expc[i], req, hits[i], expc[i]);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int cnt;
    int lins[8];
    int e4[4];
    lins = '{0, 1, 2, 3, 5, 7, 12, 255};
    rst_n = 1'b0; en = 1'b1; burst = 1'b0; sel = 1'b0; ex = '0; lin = '0;
    lead_en = 1'b0; lead_dly = '0;
    repeat (3) @(negedge clk);
    #1 check(tick == 1'b0, "reset", tick, 0);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: every exponent of the power-of-two law (R3, R7 via the idle load).
    for (int e = 0; e < 8; e++) go_burst(1'b0, e, 0, 1'b0, 0, "R1");
    // R2: linear law across a spread of divisors, including N=0.
    for (int i = 0; i < 8; i++) go_burst(1'b1, 0, lins[i], 1'b0, 0, "R2");
    // R3: first strobe position for a mid-sized period.
    go_burst(1'b1, 0, 9, 1'b0, 0, "R3");
    // R8: lead delay applied, and ignored when disabled.
    go_burst(1'b1, 0, 3, 1'b1, 9, "R8");
    go_burst(1'b0, 1, 0, 1'b1, 5, "R8");
    go_burst(1'b1, 0, 3, 1'b0, 9, "R8");
    // R9: lead enabled with zero delay.
    go_burst(1'b1, 0, 4, 1'b1, 0, "R9");
    // R7: path swap between bursts.
    go_burst(1'b0, 2, 0, 1'b0, 0, "R7");
    go_burst(1'b1, 0, 2, 1'b0, 0, "R7");

    // R6: shorten mid-burst (P 6 -> 2) and lengthen mid-burst with a path swap (2 -> 8).
    e4 = '{5, 11, 13, 15};
    mid_change(1'b1, 0, 5, 1'b1, 0, 1, 7, 17, e4, "R6");
    e4 = '{1, 3, 5, 13};
    mid_change(1'b1, 0, 1, 1'b0, 2, 0, 4, 22, e4, "R6");

    // R5: idle with enable high yields no strobes.
    @(negedge clk);
    burst = 1'b0; sel = 1'b1; lin = '0;
    cnt = 0;
    for (int c = 0; c < 20; c++) begin #1; if (tick) cnt++; @(negedge clk); end
    check(cnt == 0, "R5", cnt, 0);

    // R4: disable mid-burst silences strobes; re-enable restarts a full period.
    sel = 1'b1; lin = 8'd3; burst = 1'b1;
    repeat (6) @(negedge clk);
    en = 1'b0;
    cnt = 0;
    for (int c = 0; c < 12; c++) begin #1; if (tick) cnt++; @(negedge clk); end
    check(cnt == 0, "R4", cnt, 0);
    en = 1'b1;
    cnt = -1;
    for (int c = 0; c < 8; c++) begin
      #1;
      if (tick && cnt < 0) cnt = c;
      @(negedge clk);
    end
    check(cnt == 3, "R4", cnt, 3);
    burst = 1'b0;
    @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule